// File: doc/BRIEF.md
# Zero-Page Bit Test Branch Sequencer

This block sequences a three-byte conditional branch instruction that tests one bit of a byte in the zero page. The first byte is the opcode. The second byte is a zero-page address. The third byte is a signed displacement. The opcode selects which bit of the fetched byte is tested. It also selects whether the branch is taken when that bit is 0 or when it is 1. The instruction never indexes and never touches any processor flag.

The surrounding core raises `start` with the opcode and the opcode's address on `pc`. It then presents the two operand bytes on `operandByte` in the cycles the sequencer expects, and returns the zero-page byte on `memData`. The sequencer issues the zero-page read in the third cycle and reports the following PC with a one-cycle `done` pulse in the fifth cycle. The cycle count is the same whether the branch is taken, not taken, or lands on another page.

Top module: `zp_bit_branch`

## Requirements
- R1: After reset, `done`, `zpReadEn` and `taken` are 0 and `nextPc` is 0.
- R2: `start` is accepted only when `opcode[3:0]` is 4'hF. A start with any other low nibble produces no read, no `done` and no change to `nextPc`.
- R3: Counting the accepting `start` cycle as cycle 1, `zpReadEn` is high in cycle 3 only. In that cycle `zpReadAddr` is `{8'h00, zpByte}`, where zpByte is the value of `operandByte` in cycle 2.
- R4: `done` is high for exactly one cycle, in cycle 5, whether or not the branch is taken.
- R5: The tested bit is `memData[opcode[6:4]]`, sampled in cycle 4. If `opcode[7]` is 0, the branch is taken when that bit is 0. If `opcode[7]` is 1, the branch is taken when that bit is 1. `taken` reports the decision from cycle 5 onward.
- R6: In cycle 5, `nextPc` equals `pc + 3 + sext(disp)` when the branch is taken and `pc + 3` when it is not. Here `pc` is sampled in cycle 1 and `disp` is `operandByte` sampled in cycle 4.
- R7: The next-PC sum wraps modulo 2^16. A destination on a different page adds no cycle.
- R8: A `start` raised in cycles 2 to 4 is ignored. A `start` raised in cycle 5 begins the next instruction at once.
- R9: `nextPc` and `taken` change only in a cycle where `done` is high. They hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode present this cycle |
| opcode | input | 8 | Instruction opcode |
| operandByte | input | 8 | Zero-page address in cycle 2, displacement in cycle 4 |
| memData | input | 8 | Zero-page byte read, valid in cycle 4 |
| pc | input | ADDR_W | Address of the opcode, valid with start |
| zpReadEn | output | 1 | Zero-page read strobe |
| zpReadAddr | output | ADDR_W | Zero-page read address |
| nextPc | output | ADDR_W | Address of the next instruction |
| taken | output | 1 | Branch decision |
| done | output | 1 | Instruction complete |

## Verification
The assertions take for granted that the core delivers `operandByte` and `memData` in exactly the cycles given in R3, R5 and R6. They also assume that `pc` is meaningful whenever `start` is high. The bench keeps to this by driving each byte only in its own cycle. It places every stray `start`, including invalid opcodes and starts raised while busy, where R2 and R8 say it must be discarded. It then observes at the ports that no read or completion follows.

// File: rtl/zp_bit_branch_pkg.sv
package zp_bit_branch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_ZP, ST_READ, ST_EVAL, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic capOp;
    logic capZp;
    logic rdEn;
    logic capEval;
    logic finish;
  } seqStrobes_t;

  localparam logic [3:0] LOW_NIBBLE = 4'hF;
endpackage

// File: rtl/zp_bit_branch_ctrl.sv
module zp_bit_branch_ctrl
  import zp_bit_branch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  opcode,
  output seqStrobes_t strobes
);
  seqState_t state, stateNext;
  logic canAccept;
  logic accept;

  assign canAccept = (state == ST_IDLE) || (state == ST_DONE);
  assign accept    = start && (opcode[3:0] == LOW_NIBBLE) && canAccept;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (accept) stateNext = ST_FETCH_ZP;
      ST_FETCH_ZP: stateNext = ST_READ;
      ST_READ:     stateNext = ST_EVAL;
      ST_EVAL:     stateNext = ST_DONE;
      ST_DONE:     stateNext = accept ? ST_FETCH_ZP : ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobes.capOp   = accept;
  assign strobes.capZp   = (state == ST_FETCH_ZP);
  assign strobes.rdEn    = (state == ST_READ);
  assign strobes.capEval = (state == ST_EVAL);
  assign strobes.finish  = (state == ST_DONE);
endmodule

// File: rtl/zp_bit_branch_dp.sv
module zp_bit_branch_dp
  import zp_bit_branch_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INSTR_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [7:0]        opcode,
  input  logic [7:0]        operandByte,
  input  logic [7:0]        memData,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] zpReadAddr,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] LEN = ADDR_W'(INSTR_LEN);

  logic [7:0]        opReg;
  logic [7:0]        zpReg;
  logic [ADDR_W-1:0] pcReg;
  logic              testedBit;
  logic              takeNow;
  logic [ADDR_W-1:0] fallThrough;
  logic [ADDR_W-1:0] dispExt;

  assign testedBit   = memData[opReg[6:4]];
  assign takeNow     = opReg[7] ? testedBit : !testedBit;
  assign fallThrough = pcReg + LEN;
  assign dispExt     = {{HI_W{operandByte[7]}}, operandByte};
  assign zpReadAddr  = {{HI_W{1'b0}}, zpReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg  <= '0;
      zpReg  <= '0;
      pcReg  <= '0;
      nextPc <= '0;
      taken  <= 1'b0;
    end else begin
      if (strobes.capOp) begin
        opReg <= opcode;
        pcReg <= pc;
      end
      if (strobes.capZp) zpReg <= operandByte;
      if (strobes.capEval) begin
        taken  <= takeNow;
        nextPc <= takeNow ? fallThrough + dispExt : fallThrough;
      end
    end
  end
endmodule

// File: rtl/zp_bit_branch.sv
module zp_bit_branch
  import zp_bit_branch_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INSTR_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [7:0]        operandByte,
  input  logic [7:0]        memData,
  input  logic [ADDR_W-1:0] pc,
  output logic              zpReadEn,
  output logic [ADDR_W-1:0] zpReadAddr,
  output logic [ADDR_W-1:0] nextPc,
  output logic              taken,
  output logic              done
);
  seqStrobes_t strobes;
  logic        accepted;

  zp_bit_branch_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opcode  (opcode),
    .strobes (strobes)
  );

  zp_bit_branch_dp #(.ADDR_W(ADDR_W), .INSTR_LEN(INSTR_LEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .opcode      (opcode),
    .operandByte (operandByte),
    .memData     (memData),
    .pc          (pc),
    .zpReadAddr  (zpReadAddr),
    .nextPc      (nextPc),
    .taken       (taken)
  );

  assign accepted = strobes.capOp;
  assign zpReadEn = strobes.rdEn;
  assign done     = strobes.finish;
endmodule

// File: rtl/zp_bit_branch_chk.sv
module zp_bit_branch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [7:0]        opcode,
  input logic              accepted,
  input logic              zpReadEn,
  input logic [ADDR_W-1:0] nextPc,
  input logic              taken,
  input logic              done
);
  // R2
  a_r2_bad_opcode: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode[3:0] != 4'hF) |-> !accepted);
  // R3
  a_r3_read_slot: assert property (@(posedge clk) disable iff (!rstN)
    accepted |-> ##2 zpReadEn);
  a_r3_read_single: assert property (@(posedge clk) disable iff (!rstN)
    zpReadEn |=> !zpReadEn);
  // R4
  a_r4_done_slot: assert property (@(posedge clk) disable iff (!rstN)
    accepted |-> ##4 done);
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nextPc) |-> done);
  a_r9_taken_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(taken) |-> done);
endmodule

bind zp_bit_branch zp_bit_branch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .opcode   (opcode),
  .accepted (accepted),
  .zpReadEn (zpReadEn),
  .nextPc   (nextPc),
  .taken    (taken),
  .done     (done)
);

// File: tb/zp_bit_branch_tb.sv
module zp_bit_branch_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  operandByte = '0;
  logic [7:0]  memData = '0;
  logic [15:0] pc = '0;
  logic        zpReadEn;
  logic [15:0] zpReadAddr;
  logic [15:0] nextPc;
  logic        taken;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  curOp;
  logic [15:0] curPc;

  always #2.5 clk = ~clk;

  zp_bit_branch u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .operandByte(operandByte), .memData(memData), .pc(pc),
    .zpReadEn(zpReadEn), .zpReadAddr(zpReadAddr), .nextPc(nextPc),
    .taken(taken), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic expTaken(input logic [7:0] op, input logic [7:0] mem);
    logic b;
    b = mem[op[6:4]];
    return op[7] ? b : !b;
  endfunction

  function automatic logic [15:0] expNext(input logic [7:0] op, input logic [7:0] mem,
                                          input logic [7:0] disp, input logic [15:0] p);
    logic [15:0] ft;
    ft = p + 16'd3;
    return expTaken(op, mem) ? ft + {{8{disp[7]}}, disp} : ft;
  endfunction

  // Cycle 1: drive opcode; waitEdge=0 drives inside the current cycle.
  task automatic issue(input logic [7:0] op, input logic [15:0] p, input bit waitEdge);
    if (waitEdge) @(negedge clk);
    start = 1'b1; opcode = op; pc = p;
    curOp = op; curPc = p;
  endtask

  // Cycles 2..5; poke raises a valid start in cycle 3 (R8).
  task automatic complete(input logic [7:0] zp, input logic [7:0] mem,
                          input logic [7:0] disp, input bit poke);
    @(negedge clk);
    start = 1'b0; operandByte = zp; #1;
    check("R3 no read in cycle 2", zpReadEn, 0);
    @(negedge clk);
    operandByte = 8'hxx;
    if (poke) begin start = 1'b1; opcode = 8'h1F; pc = 16'h7777; end
    #1;
    check("R3 read strobe", zpReadEn, 1);
    check("R3 read address", zpReadAddr, {8'h00, zp});
    check("R4 no early done", done, 0);
    @(negedge clk);
    start = 1'b0; operandByte = disp; memData = mem; #1;
    check("R3 read once", zpReadEn, 0);
    check("R4 no done in cycle 4", done, 0);
    @(negedge clk);
    operandByte = 8'h00; memData = 8'h00; #1;
    check("R4 done in cycle 5", done, 1);
    check("R5 taken", taken, expTaken(curOp, mem));
    check("R6 next pc", nextPc, expNext(curOp, mem, disp, curPc));
    check("R8 no read from stray start", zpReadEn, 0);
  endtask

  task automatic idleCycle();
    logic [15:0] hold;
    hold = nextPc;
    @(negedge clk); #1;
    check("R4 done is a pulse", done, 0);
    check("R8 no read after idle", zpReadEn, 0);
    check("R9 nextPc holds", nextPc, hold);
  endtask

  task automatic testReset();
    #1;
    check("R1 done", done, 0);
    check("R1 read", zpReadEn, 0);
    check("R1 taken", taken, 0);
    check("R1 nextPc", nextPc, 0);
  endtask

  task automatic testBasic();
    issue(8'h3F, 16'h0400, 1); complete(8'h20, 8'hF7, 8'h10, 0); idleCycle(); // R5 clear bit 3 -> taken
    issue(8'hBF, 16'h0400, 1); complete(8'h21, 8'hF7, 8'h10, 0); idleCycle(); // R5 set test fails
    issue(8'hFF, 16'h1234, 1); complete(8'h80, 8'h80, 8'h05, 0); idleCycle(); // R5 bit 7 set -> taken
  endtask

  task automatic testAllBits();
    for (int b = 0; b < 8; b++) begin
      for (int pol = 0; pol < 2; pol++) begin
        issue({pol[0], b[2:0], 4'hF}, 16'h2000 + 16'(b * 16), 1);
        complete(8'(b * 3), 8'(8'h5A ^ (8'h1 << b) * pol), 8'h7F, 0);
      end
    end
  endtask

  task automatic testPageAndWrap();
    issue(8'h0F, 16'h10FE, 1); complete(8'h01, 8'h00, 8'h80, 0); // R7 backward across page
    issue(8'h0F, 16'hFFFE, 1); complete(8'hFF, 8'h00, 8'h04, 0); // R7 wrap past top
    issue(8'h8F, 16'hFFFD, 1); complete(8'h00, 8'h00, 8'h00, 0); // R7 not taken wrap to 0
    check("R7 wrap not taken", nextPc, 16'h0000);
  endtask

  task automatic testBadOpcode();
    logic [15:0] hold;
    hold = nextPc;
    @(negedge clk); start = 1'b1; opcode = 8'h1E; pc = 16'h5555;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check("R2 bad opcode no read", zpReadEn, 0);
      check("R2 bad opcode no done", done, 0);
    end
    check("R2 nextPc unchanged", nextPc, hold);
  endtask

  task automatic testBusyAndChain();
    issue(8'h2F, 16'h3000, 1); complete(8'h44, 8'h00, 8'hF0, 1); idleCycle(); // R8 poke ignored
    issue(8'h6F, 16'h3100, 1); complete(8'h45, 8'h40, 8'h02, 0);
    issue(8'hEF, 16'h3200, 0); complete(8'h46, 8'h40, 8'h08, 0);              // R8 chained in cycle 5
    idleCycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk); rstN = 1'b1;
    testBasic();
    testAllBits();
    testPageAndWrap();
    testBadOpcode();
    testBusyAndChain();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule